// File: doc/BRIEF.md
# Transmit FIR De-emphasis Level Generator

This block is a digital model of one lane's output equalizer. It receives a serial bit stream, one bit per accepted input beat. For each beat it produces a signed drive-level code. The code comes from a three-tap filter: the main cursor at fixed unit gain, one pre-cursor tap that looks at the following bit, and one post-cursor tap that looks at the preceding bit. Both side taps subtract from the main tap, with magnitudes from 0 to 1 in steps of 1/128. A 16-step swing setting scales the filter sum, and the scaled value is clipped to the signed output range. A flag marks any clipped symbol.

The input and output are valid/ready streams joined by a single output register, so each accepted bit yields exactly one output symbol. The output stage takes a new result only when it is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output code and flag hold steady and `in_ready` stays low. Input bits are not taken during that stall.

A plain write port sets the lane's configuration: swing, the two tap gains and a polarity-invert bit. A written value is used for the first symbol computed after the write, and only at an accepted beat. A symbol that is waiting in the output register never changes.

Top module: `tfir_deemph`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The delay line holds logic 0 in all three positions, both side gains are 0 and the swing code is 8. So the first symbol after reset is -768, whatever its input bit.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_level` and `out_sat` hold and no input bit is accepted.
- R3: Bit 1 maps to +1 and bit 0 maps to -1. The main cursor of a symbol is the bit accepted one beat before the one that completes that symbol.
- R4: The filter sum is 128*m - pre*p - post*q. Here m is the main bit, p is the newest bit (the pre-cursor), q is the bit before m (the post-cursor), and pre and post are the side gains in 1/128 units.
- R5: The sum is multiplied by (4 + swing) and then shifted right arithmetically by 1, rounding toward minus infinity. Swing code 0 is the smallest drive and 15 is the largest.
- R6: A scaled result above 2047 is output as 2047, and one below -2048 is output as -2048. `out_sat` is 1 exactly for clipped symbols.
- R7: Config select 1 writes the pre-cursor gain and select 2 writes the post-cursor gain, from all 8 data bits. A written value above 128 is stored as 128.
- R8: Config select 3 writes the polarity bit from data bit 0. When it is set, each bit is complemented as it enters the delay line. Bits already in the line are left as they are.
- R9: Config select 0 writes the swing from data bits 3:0. A write takes effect at the next accepted input beat and never changes a symbol already held in the output register.
- R10: One symbol comes out per accepted bit, in order. `out_valid` rises only after an acceptance and falls after a drain when no new bit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Output symbol is valid |
| out_ready | input | 1 | Consumer takes the output symbol |
| out_level | output | OUT_W | Signed drive-level code |
| out_sat | output | 1 | Symbol was clipped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 swing, 1 pre gain, 2 post gain, 3 polarity |
| cfg_wdata | input | GAIN_W | Write data |

## Verification
The bench builds the block with its defaults: a 12-bit output, 8-bit gain fields capped at 128, a swing offset of 4 and a one-bit final shift. With these values, full side gains at the top swing setting drive a transition symbol to ±3648. That is well past the output range, so both clipping limits can be reached, and the same settings stay in range at lower swings. The 8-bit gain field also lets writes of 200 and 255 exercise the cap at 128.

// File: rtl/tfir_pkg.sv
package tfir_pkg;

  typedef enum logic [1:0] {
    SEL_SWING = 2'd0,
    SEL_PRE   = 2'd1,
    SEL_POST  = 2'd2,
    SEL_POL   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic pre;
    logic main;
    logic post;
  } taps_t;

endpackage

// File: rtl/tfir_cfg_regs.sv
module tfir_cfg_regs #(
  parameter int GAIN_W    = 8,
  parameter int GAIN_MAX  = 128,
  parameter int SWING_W   = 4,
  parameter int SWING_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [GAIN_W-1:0]  wdata,
  output logic [SWING_W-1:0] swing,
  output logic [GAIN_W-1:0]  pre_gain,
  output logic [GAIN_W-1:0]  post_gain,
  output logic               pol
);
  import tfir_pkg::*;

  localparam logic [GAIN_W-1:0] CAP = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] clamped;
  assign clamped = (wdata > CAP) ? CAP : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swing     <= SWING_W'(SWING_RST);
      pre_gain  <= '0;
      post_gain <= '0;
      pol       <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_SWING: swing     <= wdata[SWING_W-1:0];
        SEL_PRE:   pre_gain  <= clamped;
        SEL_POST:  post_gain <= clamped;
        default:   pol       <= wdata[0];
      endcase
    end
  end
endmodule

// File: rtl/tfir_delay_line.sv
module tfir_delay_line (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  input  logic            pol,
  output tfir_pkg::taps_t nxt
);
  import tfir_pkg::*;

  taps_t cur;

  always_comb begin
    nxt.pre  = din ^ pol;
    nxt.main = cur.pre;
    nxt.post = cur.main;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cur <= '0;
    else if (shift_en) cur <= nxt;
  end
endmodule

// File: rtl/tfir_tap_sum.sv
module tfir_tap_sum #(
  parameter int GAIN_W   = 8,
  parameter int GAIN_MAX = 128,
  parameter int SWING_W  = 4,
  parameter int AMP_BASE = 4,
  parameter int SHIFT    = 1,
  parameter int OUT_W    = 12
) (
  input  tfir_pkg::taps_t    taps,
  input  logic [GAIN_W-1:0]  pre_gain,
  input  logic [GAIN_W-1:0]  post_gain,
  input  logic [SWING_W-1:0] swing,
  output logic [OUT_W-1:0]   level,
  output logic               sat
);
  localparam int SUM_W  = GAIN_W + 3;
  localparam int AMP_W  = SWING_W + 2;
  localparam int PROD_W = SUM_W + AMP_W;
  localparam logic signed [PROD_W-1:0] LIM_HI = PROD_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] LIM_LO = PROD_W'(-(2 ** (OUT_W - 1)));

  logic signed [SUM_W-1:0]  g_main, g_pre, g_post, t_main, t_pre, t_post, sum;
  logic signed [AMP_W-1:0]  amp;
  logic signed [PROD_W-1:0] prod, scaled;

  always_comb begin
    g_main = SUM_W'(GAIN_MAX);
    g_pre  = signed'({3'b000, pre_gain});
    g_post = signed'({3'b000, post_gain});
    t_main = taps.main ? g_main : -g_main;
    t_pre  = taps.pre  ? g_pre  : -g_pre;
    t_post = taps.post ? g_post : -g_post;
    sum    = t_main - t_pre - t_post;
    amp    = signed'({2'b00, swing}) + AMP_W'(AMP_BASE);
    prod   = PROD_W'(sum) * PROD_W'(amp);
    scaled = prod >>> SHIFT;
    if (scaled > LIM_HI) begin
      level = {1'b0, {(OUT_W - 1){1'b1}}};
      sat   = 1'b1;
    end else if (scaled < LIM_LO) begin
      level = {1'b1, {(OUT_W - 1){1'b0}}};
      sat   = 1'b1;
    end else begin
      level = scaled[OUT_W-1:0];
      sat   = 1'b0;
    end
  end
endmodule

// File: rtl/tfir_deemph.sv
module tfir_deemph #(
  parameter int GAIN_W    = 8,
  parameter int GAIN_MAX  = 128,
  parameter int SWING_W   = 4,
  parameter int SWING_RST = 8,
  parameter int AMP_BASE  = 4,
  parameter int SHIFT     = 1,
  parameter int OUT_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_bit,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_level,
  output logic                    out_sat,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [GAIN_W-1:0]       cfg_wdata
);
  import tfir_pkg::*;

  logic [SWING_W-1:0] swing;
  logic [GAIN_W-1:0]  pre_gain, post_gain;
  logic               pol, accept, sat_c;
  logic [OUT_W-1:0]   level_c;
  taps_t              taps_nxt;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  tfir_cfg_regs #(
    .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .SWING_W(SWING_W), .SWING_RST(SWING_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .swing(swing), .pre_gain(pre_gain), .post_gain(post_gain), .pol(pol)
  );

  tfir_delay_line u_dly (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_bit), .pol(pol), .nxt(taps_nxt)
  );

  tfir_tap_sum #(
    .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .SWING_W(SWING_W),
    .AMP_BASE(AMP_BASE), .SHIFT(SHIFT), .OUT_W(OUT_W)
  ) u_sum (
    .taps(taps_nxt), .pre_gain(pre_gain), .post_gain(post_gain), .swing(swing),
    .level(level_c), .sat(sat_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_level <= '0;
      out_sat   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_level <= level_c;
      out_sat   <= sat_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tfir_deemph_chk.sv
module tfir_deemph_chk #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_level,
  input logic             out_sat
);
  localparam logic [OUT_W-1:0] HI = {1'b0, {(OUT_W - 1){1'b1}}};
  localparam logic [OUT_W-1:0] LO = {1'b1, {(OUT_W - 1){1'b0}}};

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_level) && $stable(out_sat)));

  a_r2_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_sat_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> (out_level == HI || out_level == LO));

  a_r10_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_rise_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind tfir_deemph tfir_deemph_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level), .out_sat(out_sat)
);

// File: tb/tfir_deemph_tb.sv
module tfir_deemph_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_sat;
  logic signed [11:0] out_level;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;

  int n_chk = 0, n_fail = 0;
  // bench model of the requirements
  bit m_pre = 0, m_main = 0, m_post = 0, m_pol = 0;
  int m_swing = 8, m_pg = 0, m_qg = 0, exp_lvl = 0, exp_sat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfir_deemph u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level), .out_sat(out_sat),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
  );

  // fields: swing[31:28] pre[27:20] post[19:12] pol[11:8] pattern[7:0]
  localparam logic [31:0] VEC [6] = '{
    {4'd8,  8'd0,   8'd0,   4'd0, 8'b10110010},
    {4'd15, 8'd128, 8'd128, 4'd0, 8'b01010101},
    {4'd0,  8'd20,  8'd40,  4'd0, 8'b11100100},
    {4'd5,  8'd200, 8'd3,   4'd0, 8'b10011100},
    {4'd15, 8'd64,  8'd0,   4'd1, 8'b00111010},
    {4'd15, 8'd0,   8'd255, 4'd0, 8'b11001101}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cap(input int g);
    return (g > 128) ? 128 : g;
  endfunction

  task automatic model_push(input bit d);
    int s, v;
    m_post = m_main; m_main = m_pre; m_pre = d ^ m_pol;
    s = (m_main ? 128 : -128) - (m_pre ? m_pg : -m_pg) - (m_post ? m_qg : -m_qg);
    v = (s * (4 + m_swing)) >>> 1;
    exp_sat = (v > 2047 || v < -2048) ? 1 : 0;
    exp_lvl = (v > 2047) ? 2047 : (v < -2048) ? -2048 : v;
  endtask

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_swing = data & 15;
      1: m_pg = cap(data);
      2: m_qg = cap(data);
      default: m_pol = data[0];
    endcase
  endtask

  task automatic send(input bit d);
    @(negedge clk);
    in_valid = 1'b1; in_bit = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    send(1'b1);
    check(out_valid == 1'b1, "R10 valid after accept", int'(out_valid), 1);
    check(out_level == -12'sd768, "R1 first symbol", int'(out_level), -768);

    // R3: main cursor is the bit one beat earlier
    send(1'b1); check(out_level == 12'sd768, "R3 main=1", int'(out_level), 768);
    send(1'b0); check(out_level == 12'sd768, "R3 main lags one beat", int'(out_level), 768);
    send(1'b0); check(out_level == -12'sd768, "R3 main=0", int'(out_level), -768);

    // table walk: R4 R5 R6 R7 R8 against the bench model
    foreach (VEC[k]) begin
      cfg_write(0, int'(VEC[k][31:28]));
      cfg_write(1, int'(VEC[k][27:20]));
      cfg_write(2, int'(VEC[k][19:12]));
      cfg_write(3, int'(VEC[k][11:8]));
      for (int i = 7; i >= 0; i--) begin
        send(VEC[k][i]);
        check(int'(out_level) == exp_lvl, $sformatf("R4/R5/R7/R8 vec%0d bit%0d", k, i),
              int'(out_level), exp_lvl);
        check(int'(out_sat) == exp_sat, $sformatf("R6 flag vec%0d bit%0d", k, i),
              int'(out_sat), exp_sat);
      end
    end
    cfg_write(3, 0);

    // R6: both clipping limits
    cfg_write(0, 15); cfg_write(1, 128); cfg_write(2, 128);
    send(1'b0); send(1'b1); send(1'b0);
    check(out_level == 12'sd2047 && out_sat, "R6 upper clip", int'(out_level), 2047);
    send(1'b1);
    check(out_level == -12'sd2048 && out_sat, "R6 lower clip", int'(out_level), -2048);

    // R7: 200 stored as 128, so p=m=1 cancels exactly
    cfg_write(0, 8); cfg_write(1, 200); cfg_write(2, 0);
    send(1'b0); send(1'b1); send(1'b1);
    check(out_level == 12'sd0, "R7 gain capped", int'(out_level), 0);
    cfg_write(1, 0);

    // R2 / R9 / R10: stall, config write under stall, then drain
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(1'b1);
    check(int'(out_level) == exp_lvl, "R2 stalled symbol", int'(out_level), exp_lvl);
    check(in_ready == 1'b0, "R2 not ready when full", int'(in_ready), 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd15;
    @(negedge clk);
    cfg_we = 1'b0; m_swing = 15;
    in_valid = 1'b1; in_bit = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(out_level) == exp_lvl, "R9 held symbol unchanged by write", int'(out_level), exp_lvl);
    check(out_valid == 1'b1, "R2 valid held in stall", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(1'b0);
    check(int'(out_level) == exp_lvl, "R9 new swing on next beat", int'(out_level), exp_lvl);
    check(out_valid == 1'b1, "R10 replaced in drain cycle", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 empty after drain", int'(out_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule